// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads two table entries from memory through a simple request/acknowledge port. The upper ten address bits select an entry in a top-level table, whose base address software loads into a root register. That entry names the 4 KB frame that holds a second-level table. The next ten bits select the final entry in that second-level table. The final entry holds a 20-bit frame number, which is joined to the untouched 12-bit page offset.

Each request carries a read/write flag. The walker checks the valid bit of both entries and the access rights of the final entry. It returns either a physical address with a clean status, or a fault code. On success it sets the referenced bit of the final entry, and on a write it also sets the dirty bit. It stores the entry back to memory only when one of those bits actually changes. Only one walk is in flight at a time.

Entry layout, for both levels: bit 24 is valid, bit 23 is referenced, bit 22 is dirty, bits 21:20 are the access rights, and bits 19:0 are the frame number. The top-level walk uses only the valid bit and the frame number. Bits 31:25 of an entry are ignored.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req is 0.
- R2: The top-level entry is read at root + vaddr[31:22]*4. The second-level entry is read at (top entry[19:0] << 12) + vaddr[21:12]*4.
- R3: A walk that succeeds returns resp_fault 2'b00 and resp_paddr = {final entry[19:0], vaddr[11:0]}.
- R4: If bit 24 of the top-level entry is 0, the result is resp_fault 2'b01 with resp_paddr 0. The walk makes exactly one memory read and no write.
- R5: If bit 24 of the second-level entry is 0, the result is resp_fault 2'b01 with resp_paddr 0. The walk makes two reads and no write.
- R6: Access rights in bits 21:20 are decoded as 00 none, 01 read only, 10 read/write and 11 read/execute. A read of 00, or a write to anything other than 10, gives resp_fault 2'b10 with resp_paddr 0 and no write-back.
- R7: A successful access sets bit 23 of the final entry, and a successful write also sets bit 22. The updated entry is written to the address it was read from, before resp_valid.
- R8: When the bits that R7 would set are already set, no memory write occurs.
- R9: req_ready stays low from the cycle after acceptance until the cycle after resp_valid. resp_valid is a one-cycle pulse.
- R10: A root load (root_we) in the same cycle as request acceptance takes effect for that same walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the root table base register |
| root_wdata | input | 32 | New root table base (byte address) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 2 | 00 ok, 01 not present, 10 access denied |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Two events can land in the same clock edge: a root-base load and the acceptance of a request. The bench provokes this by pulsing root_we with a different top-level table while a request is being accepted. It then judges the response against a model that walks the new table. The result must show a frame that exists only in the new tables, and later walks must keep using that table. The scoreboard also counts memory reads and writes per walk and re-reads the final entry after each response. This confirms the write-back rules under every fault and rights combination.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int PFN_W  = 20;
  localparam int PTE_W  = 32;
  localparam int ENT_SH = 2;   // entries are 4 bytes
  localparam int B_VLD  = 24;
  localparam int B_REF  = 23;
  localparam int B_DRT  = 22;
  localparam int B_RGT  = 20;  // rights field low bit

  typedef enum logic [1:0] {FLT_NONE = 2'b00, FLT_PAGE = 2'b01, FLT_PROT = 2'b10} fault_e;
  typedef enum logic [2:0] {S_IDLE, S_TOP, S_LEAF, S_WB, S_RESP} walk_st_e;

  function automatic logic [VA_W-1:0] top_entry_addr(input logic [VA_W-1:0] root,
                                                     input logic [VA_W-1:0] va);
    logic [VA_W-1:0] idx;
    idx = VA_W'(va[VA_W-1 -: IDX_W]);
    return root + (idx << ENT_SH);
  endfunction

  function automatic logic [VA_W-1:0] leaf_entry_addr(input logic [VA_W-1:0] tbl,
                                                      input logic [VA_W-1:0] va);
    logic [VA_W-1:0] idx;
    idx = VA_W'(va[OFF_W +: IDX_W]);
    return tbl + (idx << ENT_SH);
  endfunction

  function automatic logic [VA_W-1:0] frame_base(input logic [PTE_W-1:0] ent);
    return {ent[PFN_W-1:0], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] join_phys(input logic [PTE_W-1:0] ent,
                                                input logic [VA_W-1:0] va);
    return {ent[PFN_W-1:0], va[OFF_W-1:0]};
  endfunction

  function automatic logic rights_permit(input logic [1:0] rgt, input logic wr);
    return wr ? (rgt == 2'b10) : (rgt != 2'b00);
  endfunction
endpackage

// File: rtl/ptw_req_hold.sv
module ptw_req_hold
  import ptw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [VA_W-1:0] vaddr_in,
  input  logic            wr_in,
  output logic [VA_W-1:0] vaddr_q,
  output logic            wr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      wr_q    <= 1'b0;
    end else if (capture) begin
      vaddr_q <= vaddr_in;
      wr_q    <= wr_in;
    end
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  output fault_e           fault,
  output logic [PTE_W-1:0] pte_new,
  output logic             need_wb
);
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask = PTE_W'(1) << B_REF;
    if (is_write) set_mask = set_mask | (PTE_W'(1) << B_DRT);
    pte_new = pte | set_mask;
    if (!pte[B_VLD])                                fault = FLT_PAGE;
    else if (!rights_permit(pte[B_RGT +: 2], is_write)) fault = FLT_PROT;
    else                                            fault = FLT_NONE;
    need_wb = (fault == FLT_NONE) && (pte_new != pte);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             root_we,
  input  logic [VA_W-1:0]  root_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             resp_valid,
  output logic [1:0]       resp_fault,
  output logic [VA_W-1:0]  resp_paddr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  walk_st_e         st;
  logic [VA_W-1:0]  root_q, tbl_q, paddr_q, vaddr_q;
  logic [PTE_W-1:0] pte_q, wb_data_q, pte_new;
  logic             wr_q, need_wb;
  fault_e           fault_q, leaf_fault;

  // named internal events
  logic walk_accept, top_done, leaf_done, wb_done, top_absent;
  assign walk_accept = (st == S_IDLE) && req_valid;
  assign top_done    = (st == S_TOP)  && mem_ack;
  assign leaf_done   = (st == S_LEAF) && mem_ack;
  assign wb_done     = (st == S_WB)   && mem_ack;
  assign top_absent  = !mem_rdata[B_VLD];

  ptw_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .capture(walk_accept),
    .vaddr_in(req_vaddr), .wr_in(req_write),
    .vaddr_q(vaddr_q), .wr_q(wr_q)
  );

  ptw_pte_eval u_eval (
    .pte(mem_rdata), .is_write(wr_q),
    .fault(leaf_fault), .pte_new(pte_new), .need_wb(need_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) root_q <= '0;
    else if (root_we) root_q <= root_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tbl_q     <= '0;
      paddr_q   <= '0;
      pte_q     <= '0;
      wb_data_q <= '0;
      fault_q   <= FLT_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (walk_accept) st <= S_TOP;
        S_TOP: if (top_done) begin
          if (top_absent) begin
            fault_q <= FLT_PAGE;
            st      <= S_RESP;
          end else begin
            tbl_q <= frame_base(mem_rdata);
            st    <= S_LEAF;
          end
        end
        S_LEAF: if (leaf_done) begin
          pte_q     <= mem_rdata;
          wb_data_q <= pte_new;
          fault_q   <= leaf_fault;
          paddr_q   <= join_phys(mem_rdata, vaddr_q);
          st        <= need_wb ? S_WB : S_RESP;
        end
        S_WB:   if (wb_done) st <= S_RESP;
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr = '0;
    if (st == S_TOP) mem_addr = top_entry_addr(root_q, vaddr_q);
    else if (st == S_LEAF || st == S_WB) mem_addr = leaf_entry_addr(tbl_q, vaddr_q);
  end

  assign mem_req    = (st == S_TOP) || (st == S_LEAF) || (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_wdata  = wb_data_q;
  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_fault = fault_q;
  assign resp_paddr = (fault_q == FLT_NONE) ? paddr_q : '0;

  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready); // R9
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
  AST_WB_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata != pte_q)); // R8
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'b00) |-> !$past(mem_we)); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == 2'b00) |-> (resp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R3
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        resp_valid;
  logic [1:0]  resp_fault;
  logic [31:0] resp_paddr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model with backdoor load port
  logic [31:0] mem [0:4095];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  int          n_rd, n_wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      n_rd <= 0;
      n_wr <= 0;
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
    end else begin
      if (bd_we) mem[bd_addr[13:2]] <= bd_data;
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  fault;
    int          rd, wr;
    logic [31:0] ent_addr, ent_val;
    bit          ent_chk;
    string       tag;
  } item_t;

  item_t sb_q[$];
  logic [31:0] root_model = '0;

  // independent restatement of the walk
  function automatic item_t predict(input logic [31:0] root, input logic [31:0] va,
                                    input bit wr, input string tag);
    item_t it;
    logic [31:0] a1, e1, a2, e2, upd;
    logic [1:0]  rg;
    it.tag = tag; it.paddr = 0; it.ent_chk = 0; it.ent_addr = 0; it.ent_val = 0; it.wr = 0;
    a1 = root + {20'd0, va[31:22], 2'b00};
    e1 = mem[a1[13:2]];
    if (!e1[24]) begin it.fault = 2'b01; it.rd = 1; return it; end
    a2 = {e1[19:0], 12'h000} + {20'd0, va[21:12], 2'b00};
    e2 = mem[a2[13:2]];
    it.rd = 2;
    if (!e2[24]) begin it.fault = 2'b01; return it; end
    rg = e2[21:20];
    if (rg == 2'b00 || (wr && rg != 2'b10)) begin
      it.fault = 2'b10; it.ent_chk = 1; it.ent_addr = a2; it.ent_val = e2; return it;
    end
    upd = e2 | 32'h0080_0000 | (wr ? 32'h0040_0000 : 32'h0);
    it.fault = 2'b00;
    it.paddr = {e2[19:0], va[11:0]};
    it.wr = (upd != e2) ? 1 : 0;
    it.ent_chk = 1; it.ent_addr = a2; it.ent_val = upd;
    return it;
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] va, input bit wr, input bit new_root,
                       input logic [31:0] root_v, input string tag);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (new_root) root_model = root_v;
    it = predict(root_model, va, wr, tag);
    sb_q.push_back(it);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    root_we = new_root; root_wdata = root_v;
    @(negedge clk);
    req_valid = 1'b0; root_we = 1'b0;
  endtask

  // monitor / scoreboard
  int  rd_base = 0, wr_base = 0;
  bit  was_resp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_resp) begin
        chk(!resp_valid && req_ready, "R9", "pulse end / ready back",
            {30'd0, resp_valid, req_ready}, 32'h1);
      end
      was_resp = resp_valid;
      if (resp_valid) begin
        item_t it;
        chk(!req_ready, "R9", "ready low at response", {31'd0, req_ready}, 32'h0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected response", 32'h1, 32'h0);
        end else begin
          it = sb_q.pop_front();
          chk(resp_fault == it.fault, it.tag, "fault", {30'd0, resp_fault}, {30'd0, it.fault});
          chk(resp_paddr == it.paddr, it.tag, "paddr", resp_paddr, it.paddr);
          chk((n_rd - rd_base) == it.rd, it.tag, "reads", n_rd - rd_base, it.rd);
          chk((n_wr - wr_base) == it.wr, it.tag, "writes", n_wr - wr_base, it.wr);
          if (it.ent_chk)
            chk(mem[it.ent_addr[13:2]] == it.ent_val, it.tag, "final entry",
                mem[it.ent_addr[13:2]], it.ent_val);
        end
        rd_base = n_rd;
        wr_base = n_wr;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1", "reset state",
        {29'd0, req_ready, resp_valid, mem_req}, 32'h4);
    // top table at 0x0000, alt top table at 0x3000
    poke(32'h0000_0120, 32'h0100_0001);   // idx 0x048 -> frame 1
    poke(32'h0000_0124, 32'h0100_0002);   // idx 0x049 -> frame 2
    poke(32'h0000_3120, 32'h0100_0002);   // alt idx 0x048 -> frame 2
    poke(32'h0000_1D14, 32'h0120_1000);   // 0x345 rw, pfn 0x01000
    poke(32'h0000_1D18, 32'h0110_0ABC);   // 0x346 read only
    poke(32'h0000_1D1C, 32'h0130_0DEF);   // 0x347 read/exec
    poke(32'h0000_1D20, 32'h0100_0123);   // 0x348 no access
    poke(32'h0000_1D24, 32'h01A0_0555);   // 0x349 rw, ref already set
    poke(32'h0000_2000, 32'h01EF_FFFF);   // frame2 idx 0: all set
    poke(32'h0000_2D14, 32'h012A_BCDE);   // frame2 idx 0x345 rw
    issue(32'h1234_5678, 0, 0, 0, "R2");  // expect 0x01000678, ref set
    issue(32'h1234_5ABC, 1, 0, 0, "R7");  // dirty set
    issue(32'h1234_5000, 1, 0, 0, "R8");  // nothing changes
    issue(32'h1234_6FFF, 0, 0, 0, "R6");  // read of read-only ok
    issue(32'h1234_6000, 1, 0, 0, "R6");  // write to read-only denied
    issue(32'h1234_7010, 1, 0, 0, "R6");  // write to read/exec denied
    issue(32'h1234_7010, 0, 0, 0, "R3");  // read of read/exec ok
    issue(32'h1234_8000, 0, 0, 0, "R6");  // no access
    issue(32'h1234_9123, 0, 0, 0, "R8");  // ref already set
    issue(32'h1234_9123, 1, 0, 0, "R7");  // dirty added
    issue(32'h1240_0FFF, 0, 0, 0, "R3");  // max frame
    issue(32'h8000_0000, 0, 0, 0, "R4");  // top entry absent
    issue(32'h1235_0000, 1, 0, 0, "R5");  // leaf entry absent
    issue(32'h1234_5678, 0, 1, 32'h0000_3000, "R10"); // root switch at accept
    issue(32'h1234_5000, 1, 0, 0, "R10"); // stays on new root
    @(negedge clk);
    while (!req_ready || sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule